// File: doc/BRIEF.md
# Byte-Lane Static RAM Model with Write-Window Checking

This block stands in for a 16-bit asynchronous static RAM with two byte lanes, so that an SRAM controller can be exercised against it inside a synchronous test or prototype. It samples the controller's select, output-enable, write-enable, lane enables, address and write data on a fast internal clock. Storage is a register array whose depth is a parameter; the low address bits index it.

Every control input passes through two flip-flops before use. A third register keeps the previous sample, so edges are found by comparing consecutive samples. The mode is decoded per lane from the synchronized controls. A write window is the set of consecutive samples in which select and write-enable are both low. The window is committed to storage in the first sample where either signal has risen, and it uses the address, data and lane enables of the window's last sample. If the window was shorter than a minimum number of samples, a one-cycle flag is raised. The write is still stored.

In read mode the data output follows the addressed word only once the address has been steady for a set number of samples. Until then the output holds the previous word.

Top module: `sram16_emu`

## Requirements
- R1: While reset is asserted and after its release, `lane_drv` is 00, `tviol` is 0 and `dout` is 0x0000 until the first read load.
- R2: With `sel_n` high, `lane_drv` is 00 regardless of every other input.
- R3: With `sel_n` low, `wr_n` high and `rd_n` low, `lane_drv[0]` is the inverse of `lo_n` and `lane_drv[1]` is the inverse of `hi_n`. Bit 0 covers `dout[7:0]` and bit 1 covers `dout[15:8]`.
- R4: With `sel_n` and `wr_n` both low, `lane_drv` is 00.
- R5: With `sel_n` low and both `wr_n` and `rd_n` high, `lane_drv` is 00.
- R6: A write window ends on the first rise of `sel_n` or `wr_n`. The low byte of `din` is stored only if `lo_n` was low, and the high byte only if `hi_n` was low. A window with both lane enables high leaves the word unchanged.
- R7: When `sel_n` and `wr_n` rise in the same sample, `lane_drv` is 00 in that sample, and the write is still stored.
- R8: When a window lasts fewer than MIN_WR samples (default 3), `tviol` pulses high for exactly one cycle, three cycles after the ending rise reaches the pins. The word is still stored. A window of MIN_WR or more samples raises no flag.
- R9: After an address change, `dout` keeps the previous word for 7 cycles and shows the new word from the 8th cycle on (4 + ACC_DLY, ACC_DLY default 4).
- R10: A change on the control pins reaches `lane_drv` after exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write enable, active low |
| lo_n | input | 1 | Low byte lane enable, active low |
| hi_n | input | 1 | High byte lane enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data from the controller |
| dout | output | 16 | Read data toward the controller |
| lane_drv | output | 2 | Per-lane drive enable (bit 0 low byte, bit 1 high byte) |
| tviol | output | 1 | One-cycle flag for a too-short write window |

## Verification
A wrong synchronizer or edge register shows up as `lane_drv` changing one cycle early or late, or as a write being lost or duplicated. A later read-back reveals that within about a dozen cycles. A wrong window counter shows within four cycles of the ending rise, as a missing, extra or stretched `tviol` pulse. A wrong lane-enable capture shows at the next read as a byte that was overwritten or was not written. A wrong address-age counter moves the cycle in which `dout` switches words, so the bench samples exactly on either side of that cycle.

// File: rtl/sram16_emu.sv
module sram16_emu #(
  parameter int ADDR_W  = 17,
  parameter int IDX_W   = 6,
  parameter int MIN_WR  = 3,
  parameter int ACC_DLY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              lo_n,
  input  logic              hi_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        lane_drv,
  output logic              tviol
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CW    = $clog2(MIN_WR + 1);
  localparam int AGW   = $clog2(ACC_DLY + 1);

  // control bundle: {sel, rd, wr, lo, hi}
  logic [4:0]        c1, c2, cp;
  logic [ADDR_W-1:0] a1, a2, ap;
  logic [15:0]       d1, d2, dp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= '1; c2 <= '1; cp <= '1;
      a1 <= '0; a2 <= '0; ap <= '0;
      d1 <= '0; d2 <= '0; dp <= '0;
    end else begin
      c1 <= {sel_n, rd_n, wr_n, lo_n, hi_n};
      c2 <= c1; cp <= c2;
      a1 <= addr; a2 <= a1; ap <= a2;
      d1 <= din;  d2 <= d1; dp <= d2;
    end
  end

  wire sel_s = c2[4], rd_s = c2[3], wr_s = c2[2], lo_s = c2[1], hi_s = c2[0];
  wire win_s   = ~sel_s & ~wr_s;
  wire win_p   = ~cp[4] & ~cp[2];
  wire commit  = win_p & ~win_s;
  wire rd_mode = ~sel_s & wr_s & ~rd_s;

  assign lane_drv = {rd_mode & ~hi_s, rd_mode & ~lo_s};

  logic [15:0] mem [DEPTH];
  wire [IDX_W-1:0] idx_w = ap[IDX_W-1:0];
  wire [IDX_W-1:0] idx_r = a2[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (commit) begin
      if (!cp[1]) mem[idx_w][7:0]  <= dp[7:0];
      if (!cp[0]) mem[idx_w][15:8] <= dp[15:8];
    end
  end

  logic [CW-1:0] wcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt  <= '0;
      tviol <= 1'b0;
    end else begin
      if (!win_s)                     wcnt <= '0;
      else if (wcnt != CW'(MIN_WR))   wcnt <= wcnt + 1'b1;
      tviol <= commit && (wcnt < CW'(MIN_WR));
    end
  end

  wire addr_chg = (a2 != ap);
  logic [AGW-1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age  <= '0;
      dout <= '0;
    end else begin
      if (addr_chg)                    age <= '0;
      else if (age != AGW'(ACC_DLY))   age <= age + 1'b1;
      if (!addr_chg && age == AGW'(ACC_DLY)) dout <= mem[idx_r];
    end
  end
endmodule

// File: rtl/sram16_emu_chk.sv
module sram16_emu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       lo_n,
  input logic       hi_n,
  input logic [1:0] lane_drv,
  input logic       tviol
);
  logic [1:0] arm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) arm <= '0;
    else if (arm != 2'd3) arm <= arm + 1'b1;
  wire live = (arm == 2'd3);

  assert_standby_float_R2: assert property (@(posedge clk) disable iff (!rst_n || !live)
    $past(sel_n, 2) |-> lane_drv == 2'b00);

  assert_read_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (!$past(sel_n, 2) && $past(wr_n, 2) && !$past(rd_n, 2))
      |-> lane_drv == ~{$past(hi_n, 2), $past(lo_n, 2)});

  assert_write_float_R4: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (!$past(sel_n, 2) && !$past(wr_n, 2)) |-> lane_drv == 2'b00);

  assert_outputs_off_R5: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (!$past(sel_n, 2) && $past(wr_n, 2) && $past(rd_n, 2)) |-> lane_drv == 2'b00);

  assert_flag_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tviol |=> !tviol);
endmodule

bind sram16_emu sram16_emu_chk u_chk (.*);

// File: tb/sram16_emu_tb.sv
`timescale 1ns/1ps
module sram16_emu_tb;
  logic clk = 0, rst_n = 0;
  logic sel_n = 1, rd_n = 1, wr_n = 1, lo_n = 1, hi_n = 1;
  logic [16:0] addr = '0;
  logic [15:0] din = '0, dout;
  logic [1:0]  lane_drv;
  logic        tviol;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sram16_emu u_dut (.clk, .rst_n, .sel_n, .rd_n, .wr_n, .lo_n, .hi_n,
                    .addr, .din, .dout, .lane_drv, .tviol);

  // {sel, rd, wr, lo, hi, expected lane_drv[1:0]}
  localparam logic [6:0] VEC [8] = '{
    7'b1010000, 7'b0010011, 7'b0010101, 7'b0011010,
    7'b0000000, 7'b0100100, 7'b1000000, 7'b0110000 };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic s, r, w, l, h);
    sel_n = s; rd_n = r; wr_n = w; lo_n = l; hi_n = h;
  endtask

  task automatic wr_cycle(input logic [16:0] a, input logic [15:0] d,
                          input logic l, h, input int len, output logic v3, v4);
    addr = a; din = d;
    ctl(0, 1, 1, l, h); tick(1);
    wr_n = 0; tick(len);
    wr_n = 1; tick(3); v3 = tviol;
    tick(1); v4 = tviol;
    sel_n = 1; tick(2);
  endtask

  task automatic rd_word(input logic [16:0] a, input logic [15:0] exp, input string tag);
    addr = a; ctl(0, 0, 1, 0, 0); tick(12);
    check(tag, dout, exp);
    sel_n = 1; tick(2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic v3, v4;
    tick(3);
    check("R1 drv in reset", 16'(lane_drv), 16'h0);
    check("R1 flag in reset", 16'(tviol), 16'h0);
    rst_n = 1; tick(3);
    check("R1 drv after reset", 16'(lane_drv), 16'h0);
    check("R1 dout after reset", dout, 16'h0);
    check("R1 flag after reset", 16'(tviol), 16'h0);

    // R10 latency
    addr = 17'd40; ctl(0, 0, 1, 0, 0); tick(1);
    check("R10 one edge", 16'(lane_drv), 16'h0);
    tick(1);
    check("R10 two edges", 16'(lane_drv), 16'h3);
    ctl(1, 1, 1, 1, 1); tick(3);

    // truth-table vectors
    for (int i = 0; i < 8; i++) begin
      string tag;
      ctl(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      tick(2);
      if (VEC[i][6])              tag = "R2 vector";
      else if (VEC[i][1:0] != 0)  tag = "R3 vector";
      else if (!VEC[i][4])        tag = "R4 vector";
      else                        tag = "R5 vector";
      check(tag, 16'(lane_drv), 16'(VEC[i][1:0]));
    end
    ctl(1, 1, 1, 1, 1); tick(4);

    // R6 lane writes
    wr_cycle(17'd5, 16'hBEEF, 0, 0, 4, v3, v4);
    check("R8 long window no flag", 16'(v3), 16'h0);
    rd_word(17'd5, 16'hBEEF, "R6 full write");
    wr_cycle(17'd5, 16'h1234, 0, 1, 4, v3, v4);
    rd_word(17'd5, 16'hBE34, "R6 low lane only");
    wr_cycle(17'd5, 16'h5600, 1, 0, 4, v3, v4);
    rd_word(17'd5, 16'h5634, "R6 high lane only");
    wr_cycle(17'd5, 16'hFFFF, 1, 1, 4, v3, v4);
    rd_word(17'd5, 16'h5634, "R6 no lane enabled");

    // R8 short window
    wr_cycle(17'd9, 16'hC0DE, 0, 0, 1, v3, v4);
    check("R8 flag raised", 16'(v3), 16'h1);
    check("R8 flag one cycle", 16'(v4), 16'h0);
    rd_word(17'd9, 16'hC0DE, "R8 short write stored");
    wr_cycle(17'd10, 16'h0A0A, 0, 0, 3, v3, v4);
    check("R8 boundary MIN_WR", 16'(v3), 16'h0);
    wr_cycle(17'd11, 16'h0B0B, 0, 0, 2, v3, v4);
    check("R8 MIN_WR-1 flagged", 16'(v3), 16'h1);

    // select-terminated write
    addr = 17'd12; din = 16'h7E57;
    ctl(1, 0, 0, 0, 0); tick(2);
    sel_n = 0; tick(3);
    check("R4 drv during window", 16'(lane_drv), 16'h0);
    sel_n = 1; tick(4);
    wr_n = 1; tick(2);
    rd_word(17'd12, 16'h7E57, "R6 select ends write");

    // R7 simultaneous rise with output enable low
    addr = 17'd20; din = 16'h9A9A;
    ctl(0, 0, 1, 0, 0); tick(1);
    wr_n = 0; tick(4);
    sel_n = 1; wr_n = 1; tick(2);
    check("R7 float at joint rise", 16'(lane_drv), 16'h0);
    tick(3);
    rd_word(17'd20, 16'h9A9A, "R7 joint rise stored");

    // R9 access delay
    addr = 17'd5; ctl(0, 0, 1, 0, 0); tick(12);
    check("R9 settled word", dout, 16'h5634);
    addr = 17'd9; tick(7);
    check("R9 previous word held", dout, 16'h5634);
    tick(1);
    check("R9 new word shown", dout, 16'hC0DE);
    ctl(1, 1, 1, 1, 1); tick(2);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule